// File: doc/BRIEF.md
# Two-User Interprocessor Mailbox Controller

The block lets two processors, user 0 and user 1, pass 32-bit words to each other through eight one-way channels. Each channel has its own four-entry queue. A direction bit for each channel decides which user fills the queue and which user drains it. Each user reaches the block through its own word-addressed register port, which has an address, write data, a write strobe, a read strobe and registered read data. Each user also has one active-high level interrupt.

A sender writes a channel's message register to queue a word. The receiver reads the same address to take the oldest word. Only the receiving side is interrupted. A sender learns that its word was consumed only by polling the channel's count or status. The block runs on one clock and has a synchronous, active-high reset.

Register map, with word addresses and NCH = 8:
- 0..7: message register of channel n.
- 8..15: status register of channel n. Bits [2:0] hold the count, bit 8 is full, bit 9 is overflow and bit 10 is the transmit role.
- 16: direction vector.
- 17: this user's interrupt-enable vector.
- 18: this user's receive-pending vector.

Top module: `mbox_ctrl`

## Requirements
- R1: Direction bit n set to 0 makes user 0 the transmitter and user 1 the receiver of channel n, and set to 1 reverses the roles. Status bit 10 reads 1 for the user that transmits on that channel. The direction register is at address 16 and either user may write it. When both users write it in the same cycle, user 0's value is kept.
- R2: Each channel queues up to four words and delivers them to its receiver in first-in, first-out order. Channels are independent of each other.
- R3: Status bits [2:0] hold the channel's count, 0 to 4, and both users can read it. Status bit 8 (full) reads 1 only for the transmitter, and only when the count is 4. The count never exceeds 4.
- R4: A transmitter write to a full channel is discarded and sets the channel's sticky overflow flag. The transmitter sees this flag as status bit 9. The transmitter clears it by writing the status register with bit 9 set. A write to a full channel is refused even when the receiver pops in the same cycle.
- R5: A receiver read of an empty channel returns 0 and leaves the queue unchanged. Later writes and reads still work in order.
- R6: A write to a message register by the non-transmitting user does not change the queue. A read of it by the non-receiving user returns 0 and does not change the queue.
- R7: A user's interrupt is high exactly while some channel that the user receives on is non-empty and enabled in that user's enable register (address 17). It falls by itself once those channels are drained. The pending vector at address 18 shows the non-empty receive channels whether or not they are enabled.
- R8: A channel never raises the interrupt of its transmitting user.
- R9: Changing a channel's direction bit empties that channel's queue and clears its overflow flag.
- R10: After reset, all directions, enables, counts, overflow flags, read data and interrupts are 0.
- R11: Read data appears on the read-data port in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| u0_addr | input | AW | User 0 word address |
| u0_wdata | input | DW | User 0 write data |
| u0_we | input | 1 | User 0 write strobe |
| u0_re | input | 1 | User 0 read strobe |
| u0_rdata | output | DW | User 0 registered read data |
| u0_irq | output | 1 | User 0 receive interrupt, level, active high |
| u1_addr | input | AW | User 1 word address |
| u1_wdata | input | DW | User 1 write data |
| u1_we | input | 1 | User 1 write strobe |
| u1_re | input | 1 | User 1 read strobe |
| u1_rdata | output | DW | User 1 registered read data |
| u1_irq | output | 1 | User 1 receive interrupt, level, active high |

## Verification
The assertions check the following on every cycle:
- No count ever exceeds four, and a count moves by at most one step unless the channel is flushed.
- A direction change leaves that channel empty.
- An interrupt is high only when an enabled, non-empty receive channel exists, and both interrupts are low when all channels are empty.
- A read of an empty channel, or a read by the wrong user, returns zero.

Only the bench's scenarios can show the following:
- The words come out in the same order they went in.
- Writes to a full channel are refused, the sticky overflow flag sets, and it clears when the transmitter writes bit 9.
- The full bit is visible only to the transmitter, and the role bits swap after a flip.
- Masked pending channels raise no interrupt.
- Read data arrives one cycle after the read strobe.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    // Status register field positions (count sits in the low bits)
    localparam int unsigned STAT_FULL_BIT = 8;
    localparam int unsigned STAT_OVF_BIT  = 9;
    localparam int unsigned STAT_TX_BIT   = 10;

    typedef enum logic {
        ROLE_RX = 1'b0,
        ROLE_TX = 1'b1
    } role_e;

    // Address map: messages, then status, then direction/enable/pending
    function automatic int unsigned addr_width(int unsigned nch);
        return $clog2(2 * nch + 3);
    endfunction
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 32,
    parameter int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          drop
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            rp;
        logic [PW-1:0]            wp;
        logic [CW-1:0]            cnt;
    } fifo_state_t;

    fifo_state_t s_d, s_q;
    logic        do_push, do_pop;

    function automatic logic [PW-1:0] ptr_next(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full    = (s_q.cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && (s_q.cnt != '0);
    assign drop    = push && full;
    assign head    = s_q.mem[s_q.rp];
    assign count   = s_q.cnt;

    always_comb begin
        s_d = s_q;
        if (do_push) begin
            s_d.mem[s_q.wp] = wdata;
            s_d.wp          = ptr_next(s_q.wp);
        end
        if (do_pop) begin
            s_d.rp = ptr_next(s_q.rp);
        end
        s_d.cnt = s_q.cnt + CW'(do_push) - CW'(do_pop);
        if (flush) begin
            s_d.rp  = '0;
            s_d.wp  = '0;
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end
endmodule

// File: rtl/mbox_port_dec.sv
module mbox_port_dec
    import mbox_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int DEPTH = 4,
    parameter int DW    = 32,
    parameter int AW    = 5,
    parameter bit UID   = 1'b0,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic [AW-1:0]           addr,
    input  logic                    we,
    input  logic                    re,
    input  logic                    clr_bit,
    input  logic [NCH-1:0]          dir,
    input  logic [NCH-1:0][DW-1:0]  head,
    input  logic [NCH-1:0][CW-1:0]  cnt,
    input  logic [NCH-1:0]          ovf,
    input  logic [NCH-1:0]          ien,
    output logic [NCH-1:0]          push,
    output logic [NCH-1:0]          pop,
    output logic [NCH-1:0]          ovf_clr,
    output logic                    dir_we,
    output logic                    ien_we,
    output logic [NCH-1:0]          pend,
    output logic [DW-1:0]           rd_val
);
    localparam int A_DIR  = 2 * NCH;
    localparam int A_IEN  = 2 * NCH + 1;
    localparam int A_PEND = 2 * NCH + 2;

    role_e [NCH-1:0] role;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            role[c] = (dir[c] == UID) ? ROLE_TX : ROLE_RX;
            pend[c] = (role[c] == ROLE_RX) && (cnt[c] != '0);
        end
    end

    assign dir_we = we && (int'(addr) == A_DIR);
    assign ien_we = we && (int'(addr) == A_IEN);

    always_comb begin
        push    = '0;
        pop     = '0;
        ovf_clr = '0;
        rd_val  = '0;
        for (int c = 0; c < NCH; c++) begin
            if (int'(addr) == c) begin
                push[c] = we && (role[c] == ROLE_TX);
                pop[c]  = re && (role[c] == ROLE_RX);
                if (role[c] == ROLE_RX && cnt[c] != '0) rd_val = head[c];
            end
            if (int'(addr) == NCH + c) begin
                ovf_clr[c]             = we && clr_bit && (role[c] == ROLE_TX);
                rd_val[CW-1:0]         = cnt[c];
                rd_val[STAT_FULL_BIT]  = (role[c] == ROLE_TX) && (cnt[c] == CW'(DEPTH));
                rd_val[STAT_OVF_BIT]   = (role[c] == ROLE_TX) && ovf[c];
                rd_val[STAT_TX_BIT]    = (role[c] == ROLE_TX);
            end
        end
        if (int'(addr) == A_DIR)  rd_val[NCH-1:0] = dir;
        if (int'(addr) == A_IEN)  rd_val[NCH-1:0] = ien;
        if (int'(addr) == A_PEND) rd_val[NCH-1:0] = pend;
    end
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
    import mbox_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int DEPTH = 4,
    parameter int DW    = 32,
    parameter int AW    = int'(mbox_pkg::addr_width(NCH))
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] u0_addr,
    input  logic [DW-1:0] u0_wdata,
    input  logic          u0_we,
    input  logic          u0_re,
    output logic [DW-1:0] u0_rdata,
    output logic          u0_irq,
    input  logic [AW-1:0] u1_addr,
    input  logic [DW-1:0] u1_wdata,
    input  logic          u1_we,
    input  logic          u1_re,
    output logic [DW-1:0] u1_rdata,
    output logic          u1_irq
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [NCH-1:0]         dir;
        logic [1:0][NCH-1:0]    ien;
        logic [NCH-1:0]         ovf;
        logic [1:0][DW-1:0]     rdata;
    } ctrl_state_t;

    ctrl_state_t s_d, s_q;

    logic [1:0][AW-1:0]       addr_a;
    logic [1:0][DW-1:0]       wdata_a;
    logic [1:0]               we_a, re_a;
    logic [1:0][NCH-1:0]      push_u, pop_u, clr_u, pend_u;
    logic [1:0]               dir_we_u, ien_we_u;
    logic [1:0][DW-1:0]       rd_val_u;
    logic [NCH-1:0][DW-1:0]   head;
    logic [NCH-1:0][CW-1:0]   cnt;
    logic [NCH-1:0]           full, drop, flush;
    logic [NCH-1:0]           dir_next;

    assign addr_a  = {u1_addr, u0_addr};
    assign wdata_a = {u1_wdata, u0_wdata};
    assign we_a    = {u1_we, u0_we};
    assign re_a    = {u1_re, u0_re};

    // User 0 wins a same-cycle direction write
    assign dir_next = dir_we_u[0] ? wdata_a[0][NCH-1:0] :
                      dir_we_u[1] ? wdata_a[1][NCH-1:0] : s_q.dir;
    assign flush    = dir_next ^ s_q.dir;

    for (genvar u = 0; u < 2; u++) begin : g_port
        mbox_port_dec #(
            .NCH(NCH), .DEPTH(DEPTH), .DW(DW), .AW(AW), .UID(u[0])
        ) u_dec (
            .addr    (addr_a[u]),
            .we      (we_a[u]),
            .re      (re_a[u]),
            .clr_bit (wdata_a[u][STAT_OVF_BIT]),
            .dir     (s_q.dir),
            .head    (head),
            .cnt     (cnt),
            .ovf     (s_q.ovf),
            .ien     (s_q.ien[u]),
            .push    (push_u[u]),
            .pop     (pop_u[u]),
            .ovf_clr (clr_u[u]),
            .dir_we  (dir_we_u[u]),
            .ien_we  (ien_we_u[u]),
            .pend    (pend_u[u]),
            .rd_val  (rd_val_u[u])
        );
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        mbox_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .push  (push_u[0][c] | push_u[1][c]),
            .pop   (pop_u[0][c] | pop_u[1][c]),
            .flush (flush[c]),
            .wdata (s_q.dir[c] ? wdata_a[1] : wdata_a[0]),
            .head  (head[c]),
            .count (cnt[c]),
            .full  (full[c]),
            .drop  (drop[c])
        );
    end

    always_comb begin
        s_d     = s_q;
        s_d.dir = dir_next;
        for (int u = 0; u < 2; u++) begin
            if (ien_we_u[u]) s_d.ien[u]   = wdata_a[u][NCH-1:0];
            if (re_a[u])     s_d.rdata[u] = rd_val_u[u];
        end
        for (int c = 0; c < NCH; c++) begin
            if (clr_u[0][c] || clr_u[1][c]) s_d.ovf[c] = 1'b0;
            if (drop[c] && full[c])         s_d.ovf[c] = 1'b1;
            if (flush[c])                   s_d.ovf[c] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign u0_rdata = s_q.rdata[0];
    assign u1_rdata = s_q.rdata[1];
    assign u0_irq   = |(pend_u[0] & s_q.ien[0]);
    assign u1_irq   = |(pend_u[1] & s_q.ien[1]);
endmodule

// File: rtl/mbox_ctrl_chk.sv
module mbox_ctrl_chk #(
    parameter int NCH   = 8,
    parameter int DEPTH = 4,
    parameter int DW    = 32,
    parameter int AW    = 5,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NCH-1:0]         dir,
    input logic [NCH-1:0][CW-1:0] cnt,
    input logic [NCH-1:0]         ien0,
    input logic [NCH-1:0]         ien1,
    input logic [AW-1:0]          u0_addr,
    input logic                   u0_re,
    input logic [DW-1:0]          u0_rdata,
    input logic                   u0_irq,
    input logic [AW-1:0]          u1_addr,
    input logic                   u1_re,
    input logic [DW-1:0]          u1_rdata,
    input logic                   u1_irq
);
    logic [NCH-1:0] nonempty;
    always_comb begin
        for (int c = 0; c < NCH; c++) nonempty[c] = (cnt[c] != '0);
    end

    // R8: an interrupt needs an enabled non-empty channel the user receives on
    a_r8_u0_rx_only: assert property (@(posedge clk) disable iff (rst)
        u0_irq |-> |(dir & nonempty & ien0));
    a_r8_u1_rx_only: assert property (@(posedge clk) disable iff (rst)
        u1_irq |-> |(~dir & nonempty & ien1));
    // R7: drained block leaves both interrupts low
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (nonempty == '0) |-> (!u0_irq && !u1_irq));

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // R3: occupancy bounded, moves at most one step unless emptied
        a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
            int'(cnt[c]) <= DEPTH);
        a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (cnt[c] == '0) ||
                     ((int'(cnt[c]) <= int'($past(cnt[c])) + 1) &&
                      (int'(cnt[c]) + 1 >= int'($past(cnt[c])))));
        // R9: a direction change empties the channel
        a_r9_flush_on_flip: assert property (@(posedge clk) disable iff (rst)
            (dir[c] != $past(dir[c])) |-> (cnt[c] == '0));
        // R5: receiver read of an empty channel returns zero
        a_r5_u0_empty_read: assert property (@(posedge clk) disable iff (rst)
            (u0_re && int'(u0_addr) == c && dir[c] && cnt[c] == '0) |=> (u0_rdata == '0));
        a_r5_u1_empty_read: assert property (@(posedge clk) disable iff (rst)
            (u1_re && int'(u1_addr) == c && !dir[c] && cnt[c] == '0) |=> (u1_rdata == '0));
        // R6: the transmitter reading its own channel gets zero
        a_r6_u0_tx_read: assert property (@(posedge clk) disable iff (rst)
            (u0_re && int'(u0_addr) == c && !dir[c]) |=> (u0_rdata == '0));
        a_r6_u1_tx_read: assert property (@(posedge clk) disable iff (rst)
            (u1_re && int'(u1_addr) == c && dir[c]) |=> (u1_rdata == '0));
    end
endmodule

bind mbox_ctrl mbox_ctrl_chk #(
    .NCH(NCH), .DEPTH(DEPTH), .DW(DW), .AW(AW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .dir      (s_q.dir),
    .cnt      (cnt),
    .ien0     (s_q.ien[0]),
    .ien1     (s_q.ien[1]),
    .u0_addr  (u0_addr),
    .u0_re    (u0_re),
    .u0_rdata (u0_rdata),
    .u0_irq   (u0_irq),
    .u1_addr  (u1_addr),
    .u1_re    (u1_re),
    .u1_rdata (u1_rdata),
    .u1_irq   (u1_irq)
);

// File: tb/mbox_ctrl_tb.sv
module mbox_ctrl_tb;
    localparam int NCH = 8, DEPTH = 4, DW = 32, AW = 5;
    localparam int A_STAT = 8, A_DIR = 16, A_IEN = 17, A_PEND = 18;

    logic clk = 0, rst = 1;
    logic [AW-1:0] a0 = 0, a1 = 0;
    logic [DW-1:0] wd0 = 0, wd1 = 0;
    logic we0 = 0, we1 = 0, re0 = 0, re1 = 0;
    logic [DW-1:0] rd0, rd1;
    logic irq0, irq1;

    int checks = 0, failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mbox_ctrl u_dut (
        .clk(clk), .rst(rst),
        .u0_addr(a0), .u0_wdata(wd0), .u0_we(we0), .u0_re(re0), .u0_rdata(rd0), .u0_irq(irq0),
        .u1_addr(a1), .u1_wdata(wd1), .u1_we(we1), .u1_re(re1), .u1_rdata(rd1), .u1_irq(irq1)
    );

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(int u, int a, logic [DW-1:0] d);
        @(negedge clk);
        if (u == 0) begin a0 = AW'(a); wd0 = d; we0 = 1; end
        else        begin a1 = AW'(a); wd1 = d; we1 = 1; end
        @(negedge clk);
        we0 = 0; we1 = 0;
    endtask

    task automatic rd(int u, int a, output logic [DW-1:0] d);
        @(negedge clk);
        if (u == 0) begin a0 = AW'(a); re0 = 1; end
        else        begin a1 = AW'(a); re1 = 1; end
        @(negedge clk);
        re0 = 0; re1 = 0;
        d = (u == 0) ? rd0 : rd1;
    endtask

    function automatic logic irq_of(int u);
        return (u == 0) ? irq0 : irq1;
    endfunction

    function automatic logic [DW-1:0] word(int ch, int d, int k);
        return 32'hA500_0000 | DW'(ch << 12) | DW'(d << 8) | DW'(k);
    endfunction

    function automatic logic [DW-1:0] stat(int count, bit full, bit ovf, bit tx);
        return DW'(count) | (DW'(full) << 8) | (DW'(ovf) << 9) | (DW'(tx) << 10);
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v, prev;
        logic [NCH-1:0] dirv;
        dirv = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R10: reset state
        chk("R10 irq0", DW'(irq0), 0);
        chk("R10 irq1", DW'(irq1), 0);
        chk("R10 rdata0", rd0, 0);
        rd(1, A_DIR, v);  chk("R10 dir", v, 0);
        rd(0, A_IEN, v);  chk("R10 ien", v, 0);
        for (int c = 0; c < NCH; c++) begin
            rd(0, A_STAT + c, v); chk("R10 status", v, stat(0, 0, 0, 1));
        end

        for (int ch = 0; ch < NCH; ch++) begin
            for (int d = 0; d < 2; d++) begin
                int tx, rx;
                tx = d; rx = 1 - d;
                dirv[ch] = d[0];
                wr(0, A_DIR, DW'(dirv));
                wr(rx, A_IEN, DW'(1) << ch);
                wr(tx, A_IEN, DW'(8'hFF));
                chk("R7 idle irq", DW'(irq_of(rx)), 0);
                rd(tx, A_STAT + ch, v); chk("R1 tx role", v, stat(0, 0, 0, 1));
                rd(rx, A_STAT + ch, v); chk("R1 rx role", v, stat(0, 0, 0, 0));

                for (int k = 0; k < DEPTH; k++) begin
                    wr(tx, ch, word(ch, d, k));
                    rd(rx, A_STAT + ch, v); chk("R3 count rx view", v, stat(k + 1, 0, 0, 0));
                end
                rd(tx, A_STAT + ch, v); chk("R3 full tx view", v, stat(4, 1, 0, 1));
                wr(tx, ch, 32'hDEAD_BEEF);
                rd(tx, A_STAT + ch, v); chk("R4 overflow sticky", v, stat(4, 1, 1, 1));
                chk("R7 rx irq", DW'(irq_of(rx)), 1);
                chk("R8 tx irq", DW'(irq_of(tx)), 0);
                rd(rx, A_PEND, v); chk("R7 pending", v, DW'(1) << ch);

                wr(rx, ch, 32'h0BAD_0BAD);
                rd(rx, A_STAT + ch, v); chk("R6 rx write ignored", v, stat(4, 0, 0, 0));
                rd(tx, ch, v); chk("R6 tx read zero", v, 0);
                rd(tx, A_STAT + ch, v); chk("R6 tx read no pop", v, stat(4, 1, 1, 1));
                rd(rx, A_STAT + ((ch + 1) % NCH), v);
                chk("R2 neighbour empty", DW'(v[2:0]), 0);

                for (int k = 0; k < DEPTH; k++) begin
                    rd(rx, ch, v); chk("R2 fifo order", v, word(ch, d, k));
                    chk("R7 irq while data", DW'(irq_of(rx)), DW'(k < DEPTH - 1));
                end
                rd(rx, ch, v); chk("R5 empty read", v, 0);
                rd(rx, A_STAT + ch, v); chk("R5 count stays 0", v, stat(0, 0, 0, 0));
                wr(tx, ch, word(ch, d, 9));
                rd(rx, ch, v); chk("R5 after empty read", v, word(ch, d, 9));

                wr(tx, A_STAT + ch, DW'(1) << 9);
                rd(tx, A_STAT + ch, v); chk("R4 overflow clear", v, stat(0, 0, 0, 1));

                wr(rx, A_IEN, 0);
                wr(tx, ch, word(ch, d, 7));
                chk("R7 masked irq", DW'(irq_of(rx)), 0);
                rd(rx, A_PEND, v); chk("R7 masked pending", v, DW'(1) << ch);

                dirv[ch] = ~d[0];
                wr(0, A_DIR, DW'(dirv));
                rd(rx, A_STAT + ch, v); chk("R9 flush and R1 swap", v, stat(0, 0, 0, 1));
                rd(rx, A_PEND, v); chk("R9 pending cleared", v, 0);
            end
        end

        // R1: simultaneous direction writes, user 0 kept
        @(negedge clk);
        a0 = AW'(A_DIR); wd0 = DW'(8'h0F); we0 = 1;
        a1 = AW'(A_DIR); wd1 = DW'(8'hF0); we1 = 1;
        @(negedge clk);
        we0 = 0; we1 = 0;
        rd(1, A_DIR, v); chk("R1 dir collision", v, DW'(8'h0F));
        wr(1, A_DIR, 0);

        // R11: one-cycle read latency
        wr(0, 0, 32'h1234_5678);
        prev = rd1;
        @(negedge clk);
        a1 = 0; re1 = 1;
        #2 chk("R11 before edge", rd1, prev);
        @(negedge clk);
        re1 = 0;
        chk("R11 after edge", rd1, 32'h1234_5678);
        repeat (2) @(negedge clk);
        chk("R11 holds", rd1, 32'h1234_5678);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule